// File: doc/BRIEF.md
# Elapsed On-Time Display Counter

This block keeps track of how long a unit has been powered and presents that time as BCD digits for a four-digit display field with a colon in the middle. A single-cycle one-second tick advances the count. For the first hour the field reads minutes:seconds. From the first full hour onward it reads hours:minutes. After 24 hours the field starts again at 0:00 in minutes:seconds form.

Every completed day also advances a separate BCD day count, which stops at its largest value (9999 with four digits). Digit-enable outputs let the display driver blank leading zeros. Both the time field and the day field have them. Segment encoding, measurement and buttons are handled elsewhere.

Top module: `ontime_disp_top`

## Requirements
- R1: A synchronous reset clears seconds, minutes, hours and days in one cycle, and it takes priority over a tick in the same cycle. After reset, time_bcd = 16'h0000, hm_mode = 0, day_bcd = 0 and day_digit_on = 1 (only the lowest digit is lit).
- R2: Each tick_1s pulse advances the elapsed count by exactly one second. In a cycle with no tick, every output holds its value.
- R3: time_bcd holds four BCD digits in display order: bits [15:8] are the left pair and bits [7:0] are the right pair. With hm_mode = 0 the left pair is minutes (0..59) and the right pair is seconds (0..59). Seconds roll from 59 to 00 and carry into minutes.
- R4: With hm_mode = 0, left_tens_on is 0 while minutes are below 10 and 1 from 10 minutes on.
- R5: When 60 minutes have elapsed, hm_mode becomes 1. The left pair then shows hours and the right pair shows minutes, so the first reading in this form is 01:00.
- R6: With hm_mode = 1, left_tens_on is 1 only once hours reach 10.
- R7: The tick that completes 24 hours returns the field to 00:00 with hm_mode = 0 and adds one to the day count.
- R8: The day count stops at all nines (9999 for four digits). Further completed days leave it unchanged, while the time field keeps wrapping.
- R9: day_digit_on bit i is 1 exactly when the day count is at least 10^i. Bit 0 is always 1.
- R10: All outputs come from count registers. They show the effect of a tick in the cycle right after the clock edge that samples that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| time_bcd | output | 16 | Four BCD display digits, left pair in [15:8] |
| hm_mode | output | 1 | 0 = minutes:seconds, 1 = hours:minutes |
| left_tens_on | output | 1 | Enable for the leftmost time digit |
| day_bcd | output | 4*DAY_DIGITS | BCD day count, digit 0 in the low nibble |
| day_digit_on | output | DAY_DIGITS | Per-digit enable for the day count |

## Verification
Every output comes straight from the count registers, plus combinational formatting. A tick driven between two rising edges therefore shows on the outputs after the very next rising edge, with no further delay, and this includes carries through all four counter stages and the day count. The bench drives the tick on the falling edge and counts the ticks it has issued. On the following falling edge it compares every output with values it derives arithmetically from that count, so each check sits exactly one edge after its stimulus. A second instance uses a short day and three day digits, so that saturation is reached within the run.

// File: rtl/ontime_pkg.sv
package ontime_pkg;

  // Two-digit BCD encoding of a small integer (0..99).
  function automatic logic [7:0] bcd2_of(input int unsigned n);
    return {4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  // Next value of a two-digit BCD counter that wraps after modv-1.
  function automatic logic [7:0] bcd2_step(input logic [7:0] v, input int unsigned modv);
    if (v == bcd2_of(modv - 1)) return 8'h00;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Next value of one BCD digit.
  function automatic logic [3:0] bcd1_step(input logic [3:0] d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

endpackage

// File: rtl/ontime_bcd_pair.sv
module ontime_bcd_pair
  import ontime_pkg::*;
#(
  parameter int unsigned MODV = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  output logic [7:0] val,
  output logic       wrap
);
  localparam logic [7:0] LAST = bcd2_of(MODV - 1);

  logic [7:0] val_q;

  always_ff @(posedge clk) begin
    if (rst)       val_q <= 8'h00;
    else if (step) val_q <= bcd2_step(val_q, MODV);
  end

  assign val  = val_q;
  assign wrap = step && (val_q == LAST);

  // R3
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (val_q[3:0] <= 4'd9) && (val_q <= LAST));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(val_q));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (val_q == 8'h00));

endmodule

// File: rtl/ontime_day_cnt.sv
module ontime_day_cnt
  import ontime_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step,
  output logic [4*DIGITS-1:0]   digits,
  output logic [DIGITS-1:0]     show,
  output logic                  sat
);
  logic [DIGITS-1:0][3:0] dig_q;
  logic [DIGITS:0]        carry;
  logic [DIGITS:0]        nz_above;
  logic [DIGITS-1:0]      is_nine;

  assign carry[0]         = step && !sat;
  assign nz_above[DIGITS] = 1'b0;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    always_ff @(posedge clk) begin
      if (rst)           dig_q[i] <= 4'd0;
      else if (carry[i]) dig_q[i] <= bcd1_step(dig_q[i]);
    end
    assign is_nine[i]   = (dig_q[i] == 4'd9);
    assign carry[i+1]   = carry[i] && is_nine[i];
    assign nz_above[i]  = (dig_q[i] != 4'd0) || nz_above[i+1];
    assign show[i]      = (i == 0) ? 1'b1 : nz_above[i];
    assign digits[4*i +: 4] = dig_q[i];
  end

  assign sat = &is_nine;

  // R8
  day_sat_chk: assert property (@(posedge clk) disable iff (rst)
    sat |=> (sat && $stable(dig_q)));

  // R9
  low_digit_on_chk: assert property (@(posedge clk) disable iff (rst)
    show[0]);

  // R2
  day_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(dig_q));

endmodule

// File: rtl/ontime_fmt.sv
module ontime_fmt (
  input  logic [7:0]  sec,
  input  logic [7:0]  mins,
  input  logic [7:0]  hrs,
  output logic [15:0] time_bcd,
  output logic        hm_mode,
  output logic        left_tens_on
);
  logic [7:0] left_pair;
  logic [7:0] right_pair;

  always_comb begin
    hm_mode      = (hrs != 8'h00);
    left_pair    = hm_mode ? hrs  : mins;
    right_pair   = hm_mode ? mins : sec;
    time_bcd     = {left_pair, right_pair};
    left_tens_on = (left_pair[7:4] != 4'd0);
  end

endmodule

// File: rtl/ontime_disp_top.sv
module ontime_disp_top #(
  parameter int unsigned SEC_MOD    = 60,
  parameter int unsigned MIN_MOD    = 60,
  parameter int unsigned HR_MOD     = 24,
  parameter int unsigned DAY_DIGITS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_1s,
  output logic [15:0]             time_bcd,
  output logic                    hm_mode,
  output logic                    left_tens_on,
  output logic [4*DAY_DIGITS-1:0] day_bcd,
  output logic [DAY_DIGITS-1:0]   day_digit_on
);
  logic [7:0] sec_q, min_q, hr_q;
  logic       sec_wrap, min_wrap, day_roll, day_sat;

  ontime_bcd_pair #(.MODV(SEC_MOD)) sec_i (
    .clk(clk), .rst(rst), .step(tick_1s),  .val(sec_q), .wrap(sec_wrap));
  ontime_bcd_pair #(.MODV(MIN_MOD)) min_i (
    .clk(clk), .rst(rst), .step(sec_wrap), .val(min_q), .wrap(min_wrap));
  ontime_bcd_pair #(.MODV(HR_MOD))  hr_i  (
    .clk(clk), .rst(rst), .step(min_wrap), .val(hr_q),  .wrap(day_roll));

  ontime_day_cnt #(.DIGITS(DAY_DIGITS)) day_i (
    .clk(clk), .rst(rst), .step(day_roll),
    .digits(day_bcd), .show(day_digit_on), .sat(day_sat));

  ontime_fmt fmt_i (
    .sec(sec_q), .mins(min_q), .hrs(hr_q),
    .time_bcd(time_bcd), .hm_mode(hm_mode), .left_tens_on(left_tens_on));

  // R7
  day_roll_chk: assert property (@(posedge clk) disable iff (rst)
    day_roll |=> (time_bcd == 16'h0000) && !hm_mode);

  // R5
  hm_enter_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hm_mode) |-> (time_bcd == 16'h0100));

  // R4
  ms_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (!hm_mode && (min_q[7:4] == 4'd0)) |-> !left_tens_on);

  // R10
  tick_visible_chk: assert property (@(posedge clk) disable iff (rst)
    tick_1s |=> (sec_q != $past(sec_q)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (time_bcd == 16'h0000) && !hm_mode && (day_bcd == '0));

  // R8
  sat_roll_chk: assert property (@(posedge clk) disable iff (rst)
    (day_sat && day_roll) |=> $stable(day_bcd));

endmodule

// File: tb/ontime_disp_top_tb.sv
module ontime_disp_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1s = 1'b0;

  logic [15:0] a_time, b_time;
  logic        a_hm, b_hm, a_lt, b_lt;
  logic [15:0] a_day;
  logic [3:0]  a_on;
  logic [11:0] b_day;
  logic [2:0]  b_on;

  int nchk  = 0;
  int nfail = 0;
  int n_a   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ontime_disp_top dut_i (
    .clk(clk), .rst(rst), .tick_1s(tick_1s),
    .time_bcd(a_time), .hm_mode(a_hm), .left_tens_on(a_lt),
    .day_bcd(a_day), .day_digit_on(a_on));

  ontime_disp_top #(.SEC_MOD(2), .MIN_MOD(2), .HR_MOD(2), .DAY_DIGITS(3)) small_i (
    .clk(clk), .rst(rst), .tick_1s(tick_1s),
    .time_bcd(b_time), .hm_mode(b_hm), .left_tens_on(b_lt),
    .day_bcd(b_day), .day_digit_on(b_on));

  function automatic logic [7:0] b2(input int v);
    return {4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [15:0] b4(input int v);
    return {4'((v / 1000) % 10), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compares one instance with the arithmetic model after n ticks.
  task automatic check_inst(input string nm, input int n, input int sm, input int mm,
                            input int hm, input int dig, input logic [15:0] t,
                            input logic mode, input logic lt, input logic [15:0] d,
                            input logic [3:0] on);
    int s, m, h, days, dmax, left, right, p;
    logic [15:0] et;
    logic [3:0]  eon;
    s = n % sm;
    m = (n / sm) % mm;
    h = (n / (sm * mm)) % hm;
    days = n / (sm * mm * hm);
    dmax = (dig == 4) ? 9999 : 999;
    if (days > dmax) days = dmax;
    left  = (h != 0) ? h : m;
    right = (h != 0) ? m : s;
    et = {b2(left), b2(right)};
    // R3 / R5 / R10: field contents one edge after the tick
    check(t == et, {nm, " R3/R10 time field"}, t, et);
    // R5: format flag
    check(mode == (h != 0), {nm, " R5 format flag"}, 16'(mode), 16'(h != 0));
    // R4 in minutes:seconds, R6 in hours:minutes
    check(lt == (left >= 10), (h != 0) ? {nm, " R6 left tens"} : {nm, " R4 left tens"},
          16'(lt), 16'(left >= 10));
    // R7 / R8: day count with saturation
    check(d == b4(days), (days == dmax) ? {nm, " R8 day sat"} : {nm, " R7 day count"},
          d, b4(days));
    // R9: per-digit enables
    p = 1;
    eon = '0;
    for (int i = 0; i < dig; i++) begin
      eon[i] = (i == 0) || (days >= p);
      p = p * 10;
    end
    check(on == eon, {nm, " R9 day enables"}, 16'(on), 16'(eon));
  endtask

  task automatic check_both();
    check_inst("A", n_a, 60, 60, 24, 4, a_time, a_hm, a_lt, a_day, a_on);
    check_inst("B", n_a,  2,  2,  2, 3, b_time, b_hm, b_lt, {4'd0, b_day}, {1'b0, b_on});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    logic [15:0] prev_t;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(a_time == 16'h0000, "R1 reset time", a_time, 16'h0000);
    check(a_day == 16'h0000 && a_on == 4'b0001, "R1 reset day", a_day, 16'h0000);
    check(!a_hm, "R1 reset format", 16'(a_hm), 16'h0);
    for (int cyc = 0; cyc < 95000; cyc++) begin
      check_both();
      prev_t = a_time;
      tick_1s = ((cyc % 97) != 5);
      if (tick_1s) n_a++;
      @(negedge clk);
      // R2: a cycle without a tick leaves the field unchanged
      if ((cyc % 97) == 5)
        check(a_time == prev_t, "R2 hold without tick", a_time, prev_t);
    end
    check_both();
    // R1: reset wins over a tick in the same cycle
    tick_1s = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    tick_1s = 1'b0;
    n_a = 0;
    @(negedge clk);
    check(a_time == 16'h0000 && a_day == 16'h0000, "R1 reset over tick", a_time, 16'h0000);
    check(b_day == 12'h000 && b_time == 16'h0000, "R1 reset small", b_time, 16'h0000);
    for (int cyc = 0; cyc < 40; cyc++) begin
      tick_1s = 1'b1;
      n_a++;
      @(negedge clk);
      check_both();
    end
    tick_1s = 1'b0;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule